// File: doc/BRIEF.md
# Exact-Count IO Bus Sequencer

This block sits between a requester and a 16-bit IO bus. The requester hands over a fragment of 1, 2 or 3 bytes, together with a physical byte address, a direction flag and right-aligned write data. The block breaks the fragment into the smallest sequence of word and byte bus cycles that touches exactly the addressed bytes. Registers on an IO bus may change state when they are read, and a byte store is not the same as a word read-modify-write. For these reasons the block never issues an extra read and never widens a write.

Reads always use whole-word cycles. The block places the returned words in a 32-bit result the way an aligned longword read would place them. The requester then extracts the bytes it needs. Writes mix word cycles and byte cycles, depending on the length and the odd or even start address. A byte cycle carries its data on the lane chosen by address bit 0 and asserts a select bit for that lane.

The requester raises `req_valid` and holds the request fields stable until `req_ready` pulses. It drops `req_valid` in the cycle that `req_ready` is seen. A length code of 0 is taken as 1.

Top module: `iobus_seq`

## Requirements
- R1: Every read cycle is a word cycle: `bus_byte` is 0, `bus_bsel` is 2'b11, and `bus_addr` is even, equal to the request address with bit 0 cleared, or that value plus 2.
- R2: A read issues one word cycle when length plus address bit 0 is at most 2. Otherwise it issues two word cycles, the first at the even base address and the second at the base plus 2.
- R3: For a single-cycle read, `rsp_rdata` holds the word in bits [31:16] with bits [15:0] zero when address bit 1 is 1. When address bit 1 is 0, the word is in bits [15:0] and bits [31:16] are zero.
- R4: For a two-cycle read, `rsp_rdata` holds the second word in bits [31:16] and the first word in bits [15:0].
- R5: A 1-byte write, at any of the four byte offsets, is exactly one byte cycle at the request address carrying write data bits [7:0].
- R6: A 2-byte write at an even address is one word cycle carrying bits [15:0]. At an odd address it is two byte cycles: bits [7:0] at the address, then bits [15:8] at the address plus 1.
- R7: A 3-byte write at an odd address is a byte cycle of bits [7:0] at the address, then a word cycle of bits [23:8] at the address plus 1.
- R8: A 3-byte write at an even address is a word cycle of bits [15:0] at the address, then a byte cycle of bits [23:16] at the address plus 2.
- R9: Lane rules. A byte cycle with address bit 0 = 0 puts its byte on `bus_wdata[7:0]` with `bus_bsel` = 2'b01. With address bit 0 = 1 it uses `bus_wdata[15:8]` with `bus_bsel` = 2'b10. In both cases the unused lane is zero. A word write uses `bus_bsel` = 2'b11.
- R10: A bus cycle keeps `bus_valid`, address, direction, size, select and data stable until the cycle in which `bus_ack` is high. The next cycle begins only after that acknowledge.
- R11: `req_ready` is a one-clock pulse in the cycle after the acknowledge of the final bus cycle, and `bus_valid` is low during it. After reset, `bus_valid` and `req_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_addr | input | AW | Physical byte address of the fragment |
| req_len | input | 2 | Fragment length in bytes (1..3) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 24 | Right-aligned write data |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read longword, valid with req_ready |
| bus_valid | output | 1 | Bus cycle in progress |
| bus_addr | output | AW | Bus cycle byte address |
| bus_write | output | 1 | Bus cycle direction |
| bus_byte | output | 1 | 1 = byte cycle, 0 = word cycle |
| bus_bsel | output | 2 | Byte-lane select |
| bus_wdata | output | 16 | Bus write data |
| bus_rdata | input | 16 | Bus read word |
| bus_ack | input | 1 | Bus cycle acknowledge |

## Verification
The bench runs every combination of byte offset 0 to 3, length 1 to 3 and direction. Offset and length together choose between one and two cycles, so this sweep separates the single-cycle and two-cycle read paths. It also separates the odd-address and even-address write splits, and puts byte cycles on both lanes. Each expected bus cycle is compared for address, size, lane select and data, and any cycle beyond the expected list is flagged, so an extra read or a widened write shows up as a mismatch. The bus responder inserts zero to two wait states, which shows whether a cycle is held until acknowledged. The read words are distinct per address, so a placement error in the 32-bit result cannot go unnoticed.

// File: rtl/iobus_pkg.sv
package iobus_pkg;

  localparam int BUS_W  = 16;
  localparam int FRAG_W = 24;
  localparam int LONG_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_BUS, ST_DONE} seq_state_e;

  typedef struct packed {
    logic             is_byte;
    logic [1:0]       add;
    logic [BUS_W-1:0] data;
  } step_t;

  // One or two bus cycles for a fragment.
  function automatic logic need_two(logic [1:0] len, logic a0, logic wr);
    if (wr) return (len == 2'd3) || ((len == 2'd2) && a0);
    return ({1'b0, len} + {2'b00, a0}) > 3'd2;
  endfunction

  // Size, address increment and raw (right-aligned) data of cycle idx.
  function automatic step_t step_of(logic idx, logic [1:0] len, logic a0,
                                    logic wr, logic [FRAG_W-1:0] d);
    step_t s;
    s.is_byte = 1'b0;
    s.add     = 2'd0;
    s.data    = '0;
    if (!wr) begin
      s.add = idx ? 2'd2 : 2'd0;
    end else begin
      case (len)
        2'd2: begin
          if (a0) begin
            s.is_byte = 1'b1;
            s.add     = idx ? 2'd1 : 2'd0;
            s.data    = idx ? {8'h00, d[15:8]} : {8'h00, d[7:0]};
          end else begin
            s.data = d[15:0];
          end
        end
        2'd3: begin
          if (a0) begin
            if (idx) begin
              s.add  = 2'd1;
              s.data = d[23:8];
            end else begin
              s.is_byte = 1'b1;
              s.data    = {8'h00, d[7:0]};
            end
          end else begin
            if (idx) begin
              s.is_byte = 1'b1;
              s.add     = 2'd2;
              s.data    = {8'h00, d[23:16]};
            end else begin
              s.data = d[15:0];
            end
          end
        end
        default: begin
          s.is_byte = 1'b1;
          s.data    = {8'h00, d[7:0]};
        end
      endcase
    end
    return s;
  endfunction

  // Position the read words as an aligned longword read would.
  function automatic logic [LONG_W-1:0] assemble(logic two, logic a1,
                                                 logic [BUS_W-1:0] w0,
                                                 logic [BUS_W-1:0] w1);
    if (two) return {w1, w0};
    if (a1)  return {w0, 16'h0000};
    return {16'h0000, w0};
  endfunction

endpackage

// File: rtl/iobus_plan.sv
module iobus_plan
  import iobus_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        len,
  input  logic              wr,
  input  logic [FRAG_W-1:0] data,
  input  logic              idx,
  output logic [AW-1:0]     cyc_addr,
  output logic              cyc_byte,
  output logic [BUS_W-1:0]  cyc_data,
  output logic              cyc_last,
  output logic              two
);
  step_t         st;
  logic [AW-1:0] base;

  always_comb begin
    st       = step_of(idx, len, addr[0], wr, data);
    two      = need_two(len, addr[0], wr);
    base     = wr ? addr : {addr[AW-1:1], 1'b0};
    cyc_addr = base + AW'(st.add);
    cyc_byte = st.is_byte;
    cyc_data = st.data;
    cyc_last = two ? idx : 1'b1;
  end
endmodule

// File: rtl/iobus_lane.sv
module iobus_lane
  import iobus_pkg::*;
(
  input  logic             is_byte,
  input  logic             a0,
  input  logic             active,
  input  logic             wr,
  input  logic [BUS_W-1:0] raw,
  output logic [BUS_W-1:0] wdata,
  output logic [1:0]       bsel
);
  always_comb begin
    wdata = '0;
    bsel  = 2'b00;
    if (active) begin
      if (is_byte) begin
        bsel = a0 ? 2'b10 : 2'b01;
        if (wr) wdata = a0 ? {raw[7:0], 8'h00} : {8'h00, raw[7:0]};
      end else begin
        bsel = 2'b11;
        if (wr) wdata = raw;
      end
    end
  end
endmodule

// File: rtl/iobus_seq.sv
module iobus_seq
  import iobus_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_len,
  input  logic              req_write,
  input  logic [FRAG_W-1:0] req_wdata,
  output logic              req_ready,
  output logic [LONG_W-1:0] rsp_rdata,
  output logic              bus_valid,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_write,
  output logic              bus_byte,
  output logic [1:0]        bus_bsel,
  output logic [BUS_W-1:0]  bus_wdata,
  input  logic [BUS_W-1:0]  bus_rdata,
  input  logic              bus_ack
);
  seq_state_e        state_q;
  logic [AW-1:0]     addr_q;
  logic [1:0]        len_q;
  logic              wr_q;
  logic [FRAG_W-1:0] data_q;
  logic              idx_q;
  logic [BUS_W-1:0]  w0_q, w1_q;

  logic              accept_evt;
  logic              ack_evt;
  logic              final_evt;
  logic [AW-1:0]     cyc_addr;
  logic              cyc_byte;
  logic [BUS_W-1:0]  cyc_data;
  logic              cyc_last;
  logic              two;

  assign accept_evt = (state_q == ST_IDLE) && req_valid;
  assign ack_evt    = (state_q == ST_BUS) && bus_ack;
  assign final_evt  = ack_evt && cyc_last;

  iobus_plan #(.AW(AW)) u_plan (
    .addr     (addr_q),
    .len      (len_q),
    .wr       (wr_q),
    .data     (data_q),
    .idx      (idx_q),
    .cyc_addr (cyc_addr),
    .cyc_byte (cyc_byte),
    .cyc_data (cyc_data),
    .cyc_last (cyc_last),
    .two      (two)
  );

  iobus_lane u_lane (
    .is_byte (cyc_byte),
    .a0      (cyc_addr[0]),
    .active  (state_q == ST_BUS),
    .wr      (wr_q),
    .raw     (cyc_data),
    .wdata   (bus_wdata),
    .bsel    (bus_bsel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      len_q   <= 2'd1;
      wr_q    <= 1'b0;
      data_q  <= '0;
      idx_q   <= 1'b0;
      w0_q    <= '0;
      w1_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept_evt) begin
          addr_q  <= req_addr;
          len_q   <= (req_len == 2'd0) ? 2'd1 : req_len;
          wr_q    <= req_write;
          data_q  <= req_wdata;
          idx_q   <= 1'b0;
          state_q <= ST_BUS;
        end
        ST_BUS: if (ack_evt) begin
          if (!wr_q) begin
            if (idx_q) w1_q <= bus_rdata;
            else       w0_q <= bus_rdata;
          end
          if (cyc_last) state_q <= ST_DONE;
          else          idx_q   <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_valid = (state_q == ST_BUS);
  assign bus_addr  = bus_valid ? cyc_addr : '0;
  assign bus_write = bus_valid && wr_q;
  assign bus_byte  = bus_valid && cyc_byte;
  assign req_ready = (state_q == ST_DONE);
  assign rsp_rdata = wr_q ? '0 : assemble(two, addr_q[1], w0_q, w1_q);
endmodule

// File: rtl/iobus_seq_chk.sv
module iobus_seq_chk
  import iobus_pkg::*;
#(
  parameter int AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_ack,
  input logic             bus_write,
  input logic             bus_byte,
  input logic [1:0]       bus_bsel,
  input logic [AW-1:0]    bus_addr,
  input logic [BUS_W-1:0] bus_wdata,
  input logic             req_ready
);
  // R1: reads use even-addressed word cycles on both lanes
  p_read_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write) |-> (!bus_byte && bus_bsel == 2'b11 && !bus_addr[0]));

  // R9: byte lane follows address bit 0, other lane is zero
  p_byte_lane_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_byte && bus_write) |->
      (bus_addr[0] ? (bus_bsel == 2'b10 && bus_wdata[7:0] == 8'h00)
                   : (bus_bsel == 2'b01 && bus_wdata[15:8] == 8'h00)));

  // R9: word writes select both lanes
  p_word_lanes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_byte) |-> (bus_bsel == 2'b11));

  // R10: an unacknowledged cycle holds still
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ack) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_write) &&
       $stable(bus_byte) && $stable(bus_bsel) && $stable(bus_wdata)));

  // R11: ready follows an acknowledge and has no bus cycle beside it
  p_ready_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> ($past(bus_ack) && $past(bus_valid) && !bus_valid));

  // R11: ready is a single-cycle pulse
  p_ready_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);
endmodule

bind iobus_seq iobus_seq_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_valid (bus_valid),
  .bus_ack   (bus_ack),
  .bus_write (bus_write),
  .bus_byte  (bus_byte),
  .bus_bsel  (bus_bsel),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .req_ready (req_ready)
);

// File: tb/iobus_seq_bench.sv
module iobus_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_len = 2'd1;
  logic          req_write = 1'b0;
  logic [23:0]   req_wdata = '0;
  logic          req_ready;
  logic [31:0]   rsp_rdata;
  logic          bus_valid;
  logic [AW-1:0] bus_addr;
  logic          bus_write;
  logic          bus_byte;
  logic [1:0]    bus_bsel;
  logic [15:0]   bus_wdata;
  logic [15:0]   bus_rdata = '0;
  logic          bus_ack = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iobus_seq #(.AW(AW)) u_iobus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_write(req_write), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_rdata(rsp_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_byte(bus_byte),
    .bus_bsel(bus_bsel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack)
  );

  typedef struct {
    logic [AW-1:0] addr;
    logic          wr;
    logic          by;
    logic [1:0]    bsel;
    logic [15:0]   wd;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   wait_left = 0;
  int   wait_seed = 0;
  int   cycles = 0;
  bit   done = 0;

  function automatic logic [15:0] mem_word(logic [AW-1:0] a);
    return {~a[7:0], a[7:0] ^ 8'hC3};
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic push(logic [AW-1:0] a, bit wr, bit by, logic [15:0] v, string tag);
    exp_t e;
    e.addr = a; e.wr = wr; e.by = by; e.tag = tag;
    if (by) begin
      e.bsel = a[0] ? 2'b10 : 2'b01;
      e.wd   = a[0] ? {v[7:0], 8'h00} : {8'h00, v[7:0]};
    end else begin
      e.bsel = 2'b11;
      e.wd   = v;
    end
    q.push_back(e);
  endtask

  // Bus responder and monitor: pops one expected cycle per acknowledge.
  always @(negedge clk) begin
    if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_valid && rst_n) begin
      if (wait_left > 0) begin
        wait_left--;
        check(bus_valid, "R10", "cycle held during wait", {31'h0, bus_valid}, 32'h1);
      end else if (q.size() == 0) begin
        check(1'b0, "R2", "unexpected extra bus cycle", {16'h0, bus_addr}, 32'h0);
        bus_ack = 1'b1;
      end else begin
        exp_t e;
        e = q.pop_front();
        check(bus_addr == e.addr, e.tag, "bus_addr", {16'h0, bus_addr}, {16'h0, e.addr});
        check(bus_write == e.wr && bus_byte == e.by, e.tag, "write/byte",
              {30'h0, bus_write, bus_byte}, {30'h0, e.wr, e.by});
        check(bus_bsel == e.bsel, "R9", "bus_bsel", {30'h0, bus_bsel}, {30'h0, e.bsel});
        if (e.wr)
          check(bus_wdata == e.wd, e.tag, "bus_wdata", {16'h0, bus_wdata}, {16'h0, e.wd});
        bus_rdata = mem_word(bus_addr);
        bus_ack   = 1'b1;
        wait_seed++;
        wait_left = wait_seed % 3;
      end
    end
  end

  task automatic run(logic [AW-1:0] a, logic [1:0] len, bit wr, logic [23:0] d);
    logic [AW-1:0] base;
    logic [31:0]   exp_rd;
    bit            two;
    string         tag;
    int            guard;
    base = {a[AW-1:1], 1'b0};
    exp_rd = '0;
    if (!wr) begin
      two = (int'(len) + int'(a[0])) > 2;
      tag = two ? "R4" : "R3";
      push(base, 0, 0, 16'h0, "R2");
      if (two) begin
        push(base + 2, 0, 0, 16'h0, "R2");
        exp_rd = {mem_word(base + 2), mem_word(base)};
      end else if (a[1]) exp_rd = {mem_word(base), 16'h0};
      else               exp_rd = {16'h0, mem_word(base)};
    end else begin
      case (len)
        2'd1: begin tag = "R5"; push(a, 1, 1, {8'h0, d[7:0]}, tag); end
        2'd2: begin
          tag = "R6";
          if (a[0]) begin
            push(a, 1, 1, {8'h0, d[7:0]}, tag);
            push(a + 1, 1, 1, {8'h0, d[15:8]}, tag);
          end else push(a, 1, 0, d[15:0], tag);
        end
        default: begin
          if (a[0]) begin
            tag = "R7";
            push(a, 1, 1, {8'h0, d[7:0]}, tag);
            push(a + 1, 1, 0, d[23:8], tag);
          end else begin
            tag = "R8";
            push(a, 1, 0, d[15:0], tag);
            push(a + 2, 1, 1, {8'h0, d[23:16]}, tag);
          end
        end
      endcase
    end
    @(negedge clk);
    req_addr = a; req_len = len; req_write = wr; req_wdata = d; req_valid = 1'b1;
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (!req_ready && guard < 200);
    req_valid = 1'b0;
    check(req_ready, "R11", "completion seen", {31'h0, req_ready}, 32'h1);
    check(q.size() == 0 && !bus_valid, "R11", "ready after last cycle, bus idle",
          {30'h0, q.size() != 0, bus_valid}, 32'h0);
    if (!wr) check(rsp_rdata == exp_rd, tag, "rsp_rdata", rsp_rdata, exp_rd);
    q.delete();
    @(negedge clk);
    check(!req_ready, "R11", "ready is one pulse", {31'h0, req_ready}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!bus_valid && !req_ready, "R11", "reset state", {30'h0, bus_valid, req_ready}, 32'h0);
    rst_n = 1'b1;
    for (int off = 0; off < 4; off++) begin
      for (int ln = 1; ln <= 3; ln++) begin
        run(AW'(16'h0140 + off), 2'(ln), 1'b0, 24'h0);
        run(AW'(16'h2A60 + off), 2'(ln), 1'b1, 24'hA1B2C3 ^ 24'(off * 24'h111111));
      end
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog: actual %0d cycles expected fewer", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule